// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block snoops the bus writes that the processor or a programming port aims at an on-chip flash array. It recognises the multi-write unlock sequences that request flash operations. Every sequence opens with the same two unlock writes. A third write selects a family of operations, and for some families further writes follow. When a sequence completes correctly, the block raises a one-cycle request pulse for the operation. In the same cycle it presents the target address and data byte that the array controller needs.

Command addresses are compared on their low 12 bits only. The upper 4 bits of a sector-erase address name a 4-kbyte sector. Which upper nibbles are legal depends on the operating mode and a bank-select bit, and in one case the nibble is remapped before it is presented. While the array reports busy, the block refuses to start a new sequence.

The write port is a plain strobe, not a stream. Every strobed write is consumed in the cycle it appears, and there is no back-pressure. A write that arrives while the array is busy and no sequence is open is dropped.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A sequence starts only with data AAh at low-12-bit address 555h, followed by data 55h at low-12-bit address AAAh. The address bits above bit 11 are ignored for both writes.
- R2: After the unlock pair, a write of A0h at 555h arms programming. The next write of any address and any data raises `pgm_req` for exactly one cycle, in the cycle after that write, with `tgt_addr` and `tgt_data` equal to that write's full address and data.
- R3: After the unlock pair, a write of 80h at 555h, then a second unlock pair, then a sixth write with data 30h raises `sect_erase_req` if the sixth address's nibble [15:12] is legal. The legal nibbles are:
  - mode 0 (MCU): 1h to Fh, presented unchanged.
  - mode 1 (serial) with `bank_sel`=1: 8h to Fh, presented unchanged.
  - mode 1 with `bank_sel`=0: 9h to Fh, presented with bit 15 cleared.

  `tgt_addr[11:0]` keeps the written low bits.
- R4: A sector-erase sixth write whose upper nibble is outside the legal range for the current mode and bank ends the sequence with no pulse.
- R5: In mode 2 (parallel) and mode 3, a sector-erase sequence issues no pulse.
- R6: The same six-write prefix ending with 10h at 555h raises `chip_erase_req` in any mode.
- R7: The unlock pair followed by 90h at 555h raises `id_enter_req`.
- R8: `id_exit_req` is raised in either of two cases: a lone write of F0h to any address while no sequence is open, or the unlock pair followed by F0h at 555h.
- R9: The unlock pair, then A5h at 555h, then 00h at the full address FF7Fh raises `secure_req`. Any other fourth write ends the sequence with no pulse.
- R10: Any write that does not match the next expected step returns the decoder to idle with no pulse. That write is not itself taken as the first unlock write.
- R11: While `array_busy` is high, writes arriving while no sequence is open are ignored and start nothing.
- R12: After reset all request pulses are low. At most one request pulse is high in any cycle, and each request lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per high cycle |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| mode | input | 2 | 0 MCU, 1 serial, 2 parallel, 3 reserved |
| bank_sel | input | 1 | Bank select used in serial mode |
| array_busy | input | 1 | Array operation in progress |
| pgm_req | output | 1 | Byte program request pulse |
| sect_erase_req | output | 1 | Sector erase request pulse |
| chip_erase_req | output | 1 | Chip erase request pulse |
| id_enter_req | output | 1 | Product-ID entry pulse |
| id_exit_req | output | 1 | Product-ID exit pulse |
| secure_req | output | 1 | Security program pulse |
| tgt_addr | output | 16 | Target address, valid with a pulse |
| tgt_data | output | 8 | Target data, valid with a pulse |

## Verification
The bench targets the sector boundaries in each mode:
- Nibble 8h with bank 0 must abort; a decoder with a loose range check would erase a sector outside the bank.
- Nibble Fh with bank 0 must appear as 7h; missing remap logic shows up as the wrong sector on `tgt_addr`.

Upper address bits on the unlock writes must be ignored, while the security address must match in full. A decoder that compares the wrong width either refuses a legal sequence or accepts a write to 7F7Fh.

A broken sequence is followed by writes that would form a program command if the decoder had stayed armed, which exposes a missing return to idle. The same follow-up writes are sent after an unlock write made while busy, which exposes a busy input that does not block the start of a sequence.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PGM, ST_ERS1, ST_ERS2, ST_ERS3, ST_SEC
  } fcd_state_e;

  typedef enum logic [1:0] {
    MODE_MCU = 2'd0, MODE_SERIAL = 2'd1, MODE_PARALLEL = 2'd2, MODE_RSVD = 2'd3
  } fcd_mode_e;

  // bit position of each command in the pulse vector is (code - 1)
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0, CMD_PGM = 3'd1, CMD_SECT = 3'd2, CMD_CHIP = 3'd3,
    CMD_IDIN = 3'd4, CMD_IDOUT = 3'd5, CMD_SECURE = 3'd6
  } fcd_cmd_e;

  localparam int unsigned NUM_CMD = 6;

  localparam logic [11:0] KEY_ADDR_A = 12'h555;
  localparam logic [11:0] KEY_ADDR_B = 12'hAAA;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;
  localparam logic [7:0]  OP_PGM     = 8'hA0;
  localparam logic [7:0]  OP_ERASE   = 8'h80;
  localparam logic [7:0]  OP_IDIN    = 8'h90;
  localparam logic [7:0]  OP_IDOUT   = 8'hF0;
  localparam logic [7:0]  OP_SECURE  = 8'hA5;
  localparam logic [7:0]  OP_SECT    = 8'h30;
  localparam logic [7:0]  OP_CHIP    = 8'h10;
  localparam logic [15:0] SECURE_ADDR = 16'hFF7F;
  localparam logic [7:0]  SECURE_DATA = 8'h00;
endpackage

// File: rtl/fcd_sector_map.sv
module fcd_sector_map
  import fcd_pkg::*;
#(
  parameter int unsigned SECT_W = 4
) (
  input  logic [1:0]        mode,
  input  logic              bank_sel,
  input  logic [SECT_W-1:0] nib,
  output logic              ok,
  output logic [SECT_W-1:0] mapped
);
  always_comb begin
    ok     = 1'b0;
    mapped = nib;
    case (fcd_mode_e'(mode))
      MODE_MCU:    ok = (nib != '0);
      MODE_SERIAL: begin
        if (bank_sel) begin
          ok = nib[SECT_W-1];
        end else begin
          // upper half of the window folds onto the lower sectors
          ok     = nib[SECT_W-1] && (nib[SECT_W-2:0] != '0);
          mapped = {1'b0, nib[SECT_W-2:0]};
        end
      end
      default:     ok = 1'b0;   // parallel and reserved refuse sector erase
    endcase
  end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CMP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              sect_ok,
  output fcd_cmd_e          cmd
);
  fcd_state_e state_q, state_d;
  logic [CMP_W-1:0] low;
  logic at_a, at_b;

  assign low  = wr_addr[CMP_W-1:0];
  assign at_a = (low == KEY_ADDR_A);
  assign at_b = (low == KEY_ADDR_B);

  always_comb begin
    state_d = state_q;
    cmd     = CMD_NONE;
    if (wr_en) begin
      state_d = ST_IDLE;
      case (state_q)
        ST_IDLE: if (!busy) begin
          if (at_a && wr_data == KEY_DATA_A) state_d = ST_UNL1;
          else if (wr_data == OP_IDOUT)      cmd = CMD_IDOUT;
        end
        ST_UNL1: if (at_b && wr_data == KEY_DATA_B) state_d = ST_UNL2;
        ST_UNL2: if (at_a) begin
          case (wr_data)
            OP_PGM:    state_d = ST_PGM;
            OP_ERASE:  state_d = ST_ERS1;
            OP_SECURE: state_d = ST_SEC;
            OP_IDIN:   cmd = CMD_IDIN;
            OP_IDOUT:  cmd = CMD_IDOUT;
            default:   state_d = ST_IDLE;
          endcase
        end
        ST_PGM:  cmd = CMD_PGM;
        ST_ERS1: if (at_a && wr_data == KEY_DATA_A) state_d = ST_ERS2;
        ST_ERS2: if (at_b && wr_data == KEY_DATA_B) state_d = ST_ERS3;
        ST_ERS3: begin
          if (wr_data == OP_SECT && sect_ok)       cmd = CMD_SECT;
          else if (wr_data == OP_CHIP && at_a)     cmd = CMD_CHIP;
        end
        ST_SEC: if (wr_addr == SECURE_ADDR && wr_data == SECURE_DATA) cmd = CMD_SECURE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R11: a write while idle and busy leaves the decoder idle
  p_busy_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && busy && wr_en) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CMP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        mode,
  input  logic              bank_sel,
  input  logic              array_busy,
  output logic              pgm_req,
  output logic              sect_erase_req,
  output logic              chip_erase_req,
  output logic              id_enter_req,
  output logic              id_exit_req,
  output logic              secure_req,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data
);
  localparam int unsigned SECT_W = ADDR_W - CMP_W;

  fcd_cmd_e          cmd;
  logic              sect_ok;
  logic [SECT_W-1:0] sect_nib;
  logic [NUM_CMD-1:0] pulse_q;

  fcd_sector_map #(.SECT_W(SECT_W)) u_map (
    .mode     (mode),
    .bank_sel (bank_sel),
    .nib      (wr_addr[ADDR_W-1:CMP_W]),
    .ok       (sect_ok),
    .mapped   (sect_nib)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .busy    (array_busy),
    .sect_ok (sect_ok),
    .cmd     (cmd)
  );

  for (genvar gi = 0; gi < NUM_CMD; gi++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q[gi] <= 1'b0;
      else        pulse_q[gi] <= (3'(cmd) == 3'(gi + 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_addr <= '0;
      tgt_data <= '0;
    end else if (cmd != CMD_NONE) begin
      tgt_addr <= (cmd == CMD_SECT) ? {sect_nib, wr_addr[CMP_W-1:0]} : wr_addr;
      tgt_data <= wr_data;
    end
  end

  assign pgm_req        = pulse_q[0];
  assign sect_erase_req = pulse_q[1];
  assign chip_erase_req = pulse_q[2];
  assign id_enter_req   = pulse_q[3];
  assign id_exit_req    = pulse_q[4];
  assign secure_req     = pulse_q[5];

  // R12: never two requests at once, program request lasts one cycle
  p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_req, sect_erase_req, chip_erase_req, id_enter_req, id_exit_req, secure_req}));
  p_pgm_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |=> !pgm_req);
  // R5: sector erase only in MCU or serial mode
  p_sect_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sect_erase_req |-> ($past(mode) == 2'd0 || $past(mode) == 2'd1));
  // R4: a presented sector is never sector zero
  p_sect_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sect_erase_req |-> (tgt_addr[ADDR_W-1:CMP_W] != '0));
  // R9: security request carries the fixed address and data
  p_secure_tgt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    secure_req |-> (tgt_addr == SECURE_ADDR && tgt_data == SECURE_DATA));
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] a;
    logic [7:0]  d;
    logic [1:0]  m;
    logic        b;
    logic [5:0]  e;    // {secure,id_exit,id_enter,chip,sect,pgm}
    logic [15:0] ea;
    logic [7:0]  ed;
  } vec_t;

  localparam int NV = 60;
  localparam vec_t VEC [NV] = '{
    // R1 upper bits ignored on unlock, R2 byte program
    '{4'd1, 16'hF555, 8'hAA, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd1, 16'h3AAA, 8'h55, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd2, 16'h0555, 8'hA0, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd2, 16'h3456, 8'h5A, 2'd0, 1'b0, 6'h01, 16'h3456, 8'h5A},
    // R3 sector erase, MCU mode
    '{4'd3, 16'h0555, 8'hAA, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'h0AAA, 8'h55, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'h0555, 8'h80, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'h0555, 8'hAA, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'h0AAA, 8'h55, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'h7123, 8'h30, 2'd0, 1'b0, 6'h02, 16'h7123, 8'h30},
    // R3 serial bank 0, F nibble folds to 7
    '{4'd3, 16'h0555, 8'hAA, 2'd1, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'h0AAA, 8'h55, 2'd1, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'h0555, 8'h80, 2'd1, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'h0555, 8'hAA, 2'd1, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'h0AAA, 8'h55, 2'd1, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'hF010, 8'h30, 2'd1, 1'b0, 6'h02, 16'h7010, 8'h30},
    // R3 serial bank 1, 8 nibble kept
    '{4'd3, 16'h0555, 8'hAA, 2'd1, 1'b1, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'h0AAA, 8'h55, 2'd1, 1'b1, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'h0555, 8'h80, 2'd1, 1'b1, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'h0555, 8'hAA, 2'd1, 1'b1, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'h0AAA, 8'h55, 2'd1, 1'b1, 6'h00, 16'h0000, 8'h00},
    '{4'd3, 16'h8020, 8'h30, 2'd1, 1'b1, 6'h02, 16'h8020, 8'h30},
    // R4 serial bank 0, nibble 8 out of range
    '{4'd4, 16'h0555, 8'hAA, 2'd1, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd4, 16'h0AAA, 8'h55, 2'd1, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd4, 16'h0555, 8'h80, 2'd1, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd4, 16'h0555, 8'hAA, 2'd1, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd4, 16'h0AAA, 8'h55, 2'd1, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd4, 16'h8000, 8'h30, 2'd1, 1'b0, 6'h00, 16'h0000, 8'h00},
    // R5 parallel mode refuses sector erase
    '{4'd5, 16'h0555, 8'hAA, 2'd2, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd5, 16'h0AAA, 8'h55, 2'd2, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd5, 16'h0555, 8'h80, 2'd2, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd5, 16'h0555, 8'hAA, 2'd2, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd5, 16'h0AAA, 8'h55, 2'd2, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd5, 16'h7000, 8'h30, 2'd2, 1'b0, 6'h00, 16'h0000, 8'h00},
    // R6 chip erase, accepted in parallel mode
    '{4'd6, 16'h0555, 8'hAA, 2'd2, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd6, 16'h0AAA, 8'h55, 2'd2, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd6, 16'h0555, 8'h80, 2'd2, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd6, 16'h0555, 8'hAA, 2'd2, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd6, 16'h0AAA, 8'h55, 2'd2, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd6, 16'h1555, 8'h10, 2'd2, 1'b0, 6'h04, 16'h1555, 8'h10},
    // R7 product-ID entry
    '{4'd7, 16'h0555, 8'hAA, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd7, 16'h0AAA, 8'h55, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd7, 16'h0555, 8'h90, 2'd0, 1'b0, 6'h08, 16'h0555, 8'h90},
    // R8 short and long exit
    '{4'd8, 16'h1234, 8'hF0, 2'd0, 1'b0, 6'h10, 16'h1234, 8'hF0},
    '{4'd8, 16'h0555, 8'hAA, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd8, 16'h0AAA, 8'h55, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd8, 16'h0555, 8'hF0, 2'd0, 1'b0, 6'h10, 16'h0555, 8'hF0},
    // R9 security program, then wrong upper bits
    '{4'd9, 16'h0555, 8'hAA, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd9, 16'h0AAA, 8'h55, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd9, 16'h0555, 8'hA5, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd9, 16'hFF7F, 8'h00, 2'd0, 1'b0, 6'h20, 16'hFF7F, 8'h00},
    '{4'd9, 16'h0555, 8'hAA, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd9, 16'h0AAA, 8'h55, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd9, 16'h0555, 8'hA5, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd9, 16'h7F7F, 8'h00, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    // R10 broken unlock, then the tail of a program sequence
    '{4'd10, 16'h0555, 8'hAA, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd10, 16'h0555, 8'h55, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd10, 16'h0AAA, 8'h55, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd10, 16'h0555, 8'hA0, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00},
    '{4'd10, 16'h1000, 8'h11, 2'd0, 1'b0, 6'h00, 16'h0000, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  mode = '0;
  logic bank_sel = 1'b0;
  logic array_busy = 1'b0;
  logic pgm_req, sect_erase_req, chip_erase_req, id_enter_req, id_exit_req, secure_req;
  logic [15:0] tgt_addr;
  logic [7:0]  tgt_data;
  logic [5:0]  pv;
  int checks = 0;
  int errors = 0;

  assign pv = {secure_req, id_exit_req, id_enter_req, chip_erase_req, sect_erase_req, pgm_req};

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .bank_sel(bank_sel), .array_busy(array_busy),
    .pgm_req(pgm_req), .sect_erase_req(sect_erase_req), .chip_erase_req(chip_erase_req),
    .id_enter_req(id_enter_req), .id_exit_req(id_exit_req), .secure_req(secure_req),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one write at a falling edge, return at the next falling edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [1:0] m,
                    input logic b);
    wr_en = 1'b1; wr_addr = a; wr_data = d; mode = m; bank_sel = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R0 watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(12, 32'(pv), 0, "pulses in reset");                 // R12
    rst_n = 1'b1;
    @(negedge clk);
    check(12, 32'(pv), 0, "pulses after reset");              // R12

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].a, VEC[i].d, VEC[i].m, VEC[i].b);
      check(int'(VEC[i].req), 32'(pv), 32'(VEC[i].e), $sformatf("pulses vec %0d", i));
      if (VEC[i].e != 0) begin
        check(int'(VEC[i].req), 32'(tgt_addr), 32'(VEC[i].ea), $sformatf("addr vec %0d", i));
        check(int'(VEC[i].req), 32'(tgt_data), 32'(VEC[i].ed), $sformatf("data vec %0d", i));
      end
    end

    // R11: unlock write while busy is dropped, tail must not program
    array_busy = 1'b1;
    wr(16'h0555, 8'hAA, 2'd0, 1'b0);
    array_busy = 1'b0;
    wr(16'h0AAA, 8'h55, 2'd0, 1'b0);
    wr(16'h0555, 8'hA0, 2'd0, 1'b0);
    wr(16'h2000, 8'h33, 2'd0, 1'b0);
    check(11, 32'(pv), 0, "busy start suppressed");
    // R11: lone exit write while busy is also dropped
    array_busy = 1'b1;
    wr(16'h0100, 8'hF0, 2'd0, 1'b0);
    check(11, 32'(pv), 0, "busy exit suppressed");
    array_busy = 1'b0;

    // R12: program pulse lasts one cycle, R2 target stays captured
    wr(16'h0555, 8'hAA, 2'd0, 1'b0);
    wr(16'h0AAA, 8'h55, 2'd0, 1'b0);
    wr(16'h0555, 8'hA0, 2'd0, 1'b0);
    wr(16'hABCD, 8'hC3, 2'd0, 1'b0);
    check(2, 32'(pv), 32'h01, "program pulse");
    check(2, 32'(tgt_addr), 32'hABCD, "program addr");
    @(negedge clk);
    check(12, 32'(pv), 0, "pulse dropped after one cycle");

    finish_run();
  end
endmodule